// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus-side control logic of a byte-addressed serial memory that sits on a two-wire clock/data bus. Both bus lines are sampled with a fast system clock. After a Start condition, the block collects a device select byte. That byte carries a fixed four-bit type code, two chip-enable bits and a direction flag. The block acknowledges the byte only when the type code matches and the chip-enable bits equal the levels strapped on its own pins. Up to four such targets can therefore share one bus.

Once the block has answered, it serves the usual serial memory transfers through a simple synchronous memory port. Write transfers load a byte pointer from the address bytes and then store one or more data bytes. A page-write burst wraps inside a 256-byte page. Read transfers return bytes starting at the pointer. A random read is formed by a write-direction select, the address bytes, a repeated Start and a read-direction select. A read continues for as long as the bus master acknowledges each byte. A write-lock input blocks all stores to the memory.

Top module: `twi_mem_target`

## Requirements
- R1: While reset is asserted and right after it is released, the data-line pull-down (`sda_drive_o`) is off and neither memory strobe is active.
- R2: A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high. Each Start, including a repeated one, restarts reception of a select byte. After a Stop, the pull-down is off from the next clock and stays off until the next Start.
- R3: The select byte is received MSB first. It is acknowledged only when bits [7:4] equal 4'b1010 and bits [3:2] equal `ce_i[1:0]`. To acknowledge, the block pulls SDA low (`sda_drive_o`=1) while SCL is high on the ninth clock. Bit 1 plays no part in the match.
- R4: After a select byte that does not match, the block never pulls SDA low until the next Start, whatever bytes follow.
- R5: Bit 0 of the select byte is the direction (1 = read, 0 = write). A write-direction select is followed by ADDR_W/8 address bytes, most significant byte first. Each address byte is acknowledged, and together they load the byte pointer.
- R6: With `wr_lock_i` low, every data byte of a write is acknowledged and stored exactly once. The store is a single-cycle `mem_we_o` carrying the pointer and the byte. The pointer then advances.
- R7: During a write, the pointer advances only in its low 8 bits, so a burst wraps inside the current 256-byte page.
- R8: With `wr_lock_i` high, a write data byte is not acknowledged and no `mem_we_o` is issued. The memory keeps its contents.
- R9: A read-direction select alone returns the byte at the pointer. The byte goes out MSB first, with `sda_drive_o`=1 meaning a 0 bit, and the pointer then advances. The pull-down changes only while SCL is low.
- R10: A write select, the address bytes, a repeated Start and a read select together return the byte at that address.
- R11: A read continues with the next byte after each master acknowledge. The pointer advances across page boundaries and wraps from the top of the address space to 0.
- R12: After a master no-acknowledge, the block stops driving for the rest of the transaction. Each read fetch is a single-cycle `mem_re_o`, and its data is taken on `mem_rdata_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_o | output | 1 | 1 pulls the data line low |
| ce_i | input | 2 | Strapped chip-enable address |
| wr_lock_i | input | 1 | 1 blocks all memory stores |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_we_o | output | 1 | Single-cycle store strobe |
| mem_wdata_o | output | 8 | Byte to store |
| mem_re_o | output | 1 | Single-cycle fetch strobe |
| mem_rdata_i | input | 8 | Fetched byte, valid one cycle after the strobe |

## Verification
A wrong phase or bit count shows up on `sda_drive_o` within the same byte. An acknowledge then lands on the wrong clock, or a read bit is driven during the master's acknowledge slot, and the bench sees it during the very next SCL high period. A wrong pointer cannot be seen at a port until the next store or read. It appears as a mismatched `mem_addr_o` on the store strobe, or as a wrong data bit on the first read of the following transaction. For this reason, every write is followed by a random or current-address read of the same bytes.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SEL   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4
    } phase_e;

    localparam logic [3:0] MEM_TYPE_CODE = 4'b1010;
    localparam logic [3:0] BIT_ACK_SLOT  = 4'd8;
    localparam logic [3:0] BIT_ACK_DONE  = 4'd9;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o,
    output logic prv_o
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign lvl_o = chain_q[STAGES-1];
    assign prv_o = chain_q[STAGES];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic scl_lvl_i,
    input  logic scl_prv_i,
    input  logic sda_lvl_i,
    input  logic sda_prv_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_held;

    always_comb begin
        scl_held = scl_lvl_i & scl_prv_i;
        start_o  = scl_held & sda_prv_i & ~sda_lvl_i;
        stop_o   = scl_held & ~sda_prv_i & sda_lvl_i;
        rise_o   = scl_lvl_i & ~scl_prv_i;
        fall_o   = ~scl_lvl_i & scl_prv_i;
    end
endmodule

// File: rtl/tw_sel_match.sv
module tw_sel_match #(
    parameter logic [3:0] TYPE_CODE = 4'b1010
) (
    input  logic [5:0] sel_hi_i,
    input  logic [1:0] ce_i,
    output logic       hit_o
);
    always_comb begin
        hit_o = (sel_hi_i[5:2] == TYPE_CODE) && (sel_hi_i[1:0] == ce_i);
    end
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
    import tw_mem_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_o,
    input  logic [1:0]        ce_i,
    input  logic              wr_lock_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_re_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ABYTE_W    = $clog2(ADDR_BYTES + 1);
    localparam int N_LINES    = 2;

    typedef struct packed {
        phase_e              ph;
        phase_e              nxt;
        logic [3:0]          bits;
        logic [7:0]          sh;
        logic [7:0]          rbuf;
        logic                rd_wait;
        logic [ADDR_W-1:0]   ptr;
        logic [ABYTE_W-1:0]  abyte;
        logic                drive;
        logic                we;
        logic                re;
        logic [ADDR_W-1:0]   maddr;
        logic [7:0]          wdata;
    } ctl_t;

    ctl_t q, n;

    logic [N_LINES-1:0] raw_w, lvl_w, prv_w;
    logic scl_lvl, sda_lvl;
    logic start_w, stop_w, rise_w, fall_w;
    logic sel_hit;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_w[g]),
            .lvl_o (lvl_w[g]),
            .prv_o (prv_w[g])
        );
    end

    assign scl_lvl = lvl_w[0];
    assign sda_lvl = lvl_w[1];

    tw_bus_events u_events (
        .scl_lvl_i (lvl_w[0]),
        .scl_prv_i (prv_w[0]),
        .sda_lvl_i (lvl_w[1]),
        .sda_prv_i (prv_w[1]),
        .start_o   (start_w),
        .stop_o    (stop_w),
        .rise_o    (rise_w),
        .fall_o    (fall_w)
    );

    tw_sel_match #(.TYPE_CODE(MEM_TYPE_CODE)) u_match (
        .sel_hi_i (q.sh[7:2]),
        .ce_i     (ce_i),
        .hit_o    (sel_hit)
    );

    always_comb begin
        n         = q;
        n.we      = 1'b0;
        n.re      = 1'b0;
        n.rd_wait = q.re;
        if (q.rd_wait) n.rbuf = mem_rdata_i;

        if (start_w) begin
            n.ph    = PH_SEL;
            n.bits  = '0;
            n.drive = 1'b0;
        end else if (stop_w) begin
            n.ph    = PH_IDLE;
            n.bits  = '0;
            n.drive = 1'b0;
        end else if (q.ph != PH_IDLE) begin
            if (rise_w) begin
                if (q.bits < BIT_ACK_SLOT) begin
                    if (q.ph != PH_RDATA) n.sh = {q.sh[6:0], sda_lvl};
                    n.bits = q.bits + 4'd1;
                end else if (q.bits == BIT_ACK_SLOT) begin
                    n.bits = BIT_ACK_DONE;
                    if (q.ph == PH_RDATA) begin
                        if (!sda_lvl) begin
                            n.nxt   = PH_RDATA;
                            n.re    = 1'b1;
                            n.maddr = q.ptr;
                            n.ptr   = q.ptr + ADDR_W'(1);
                        end else begin
                            n.nxt = PH_IDLE;
                        end
                    end
                end
            end else if (fall_w) begin
                if (q.bits == BIT_ACK_SLOT) begin
                    case (q.ph)
                        PH_SEL: begin
                            if (sel_hit) begin
                                n.drive = 1'b1;
                                if (q.sh[0]) begin
                                    n.nxt   = PH_RDATA;
                                    n.re    = 1'b1;
                                    n.maddr = q.ptr;
                                    n.ptr   = q.ptr + ADDR_W'(1);
                                end else begin
                                    n.nxt   = PH_ADDR;
                                    n.abyte = '0;
                                end
                            end else begin
                                n.ph = PH_IDLE;
                            end
                        end
                        PH_ADDR: begin
                            n.drive = 1'b1;
                            n.ptr   = (q.ptr << 8) | ADDR_W'(q.sh);
                            n.abyte = q.abyte + ABYTE_W'(1);
                            n.nxt   = (q.abyte == ABYTE_W'(ADDR_BYTES - 1)) ? PH_WDATA : PH_ADDR;
                        end
                        PH_WDATA: begin
                            if (!wr_lock_i) begin
                                n.drive = 1'b1;
                                n.we    = 1'b1;
                                n.maddr = q.ptr;
                                n.wdata = q.sh;
                                n.ptr   = {q.ptr[ADDR_W-1:PAGE_W], q.ptr[PAGE_W-1:0] + PAGE_W'(1)};
                                n.nxt   = PH_WDATA;
                            end else begin
                                n.nxt = PH_IDLE;
                            end
                        end
                        PH_RDATA: n.drive = 1'b0;
                        default:  n.drive = 1'b0;
                    endcase
                end else if (q.bits == BIT_ACK_DONE) begin
                    n.bits = '0;
                    n.ph   = q.nxt;
                    if (q.nxt == PH_RDATA) begin
                        n.sh    = q.rbuf;
                        n.drive = ~q.rbuf[7];
                    end else begin
                        n.drive = 1'b0;
                    end
                end else if (q.ph == PH_RDATA) begin
                    n.sh    = {q.sh[6:0], 1'b0};
                    n.drive = ~q.sh[6];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_drive_o = q.drive;
    assign mem_addr_o  = q.maddr;
    assign mem_we_o    = q.we;
    assign mem_wdata_o = q.wdata;
    assign mem_re_o    = q.re;
endmodule

// File: rtl/tw_mem_target_chk.sv
module tw_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_drive_o,
    input logic mem_we_o,
    input logic mem_re_o,
    input logic wr_lock_i,
    input logic stop_w,
    input logic scl_lvl
);
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> !sda_drive_o);

    a_r6_store_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    a_r6_no_store_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    a_r8_lock_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !$past(wr_lock_i));

    a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_o) |-> !scl_lvl);

    a_r12_fetch_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> !mem_re_o);
endmodule

bind twi_mem_target tw_mem_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_drive_o (sda_drive_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .wr_lock_i   (wr_lock_i),
    .stop_w      (stop_w),
    .scl_lvl     (scl_lvl)
);

// File: tb/tb_twi_mem_target.sv
module tb_twi_mem_target;
    localparam int AW = 16;
    localparam int LO = 6;
    localparam int HI = 6;
    localparam logic [7:0] SEL_W = 8'hA8;
    localparam logic [7:0] SEL_R = 8'hA9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] ce = 2'b10;
    logic lock = 1'b0;
    logic sda_drive_o, mem_we_o, mem_re_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic [7:0] mem_rdata;
    logic sda_line;

    int vec = 0;
    int miss = 0;
    logic chk_en = 1'b0;
    logic exp_drv = 1'b0;
    string tag = "R1";
    int ref_ptr = 0;
    logic [7:0] ref_mem [int];
    logic [7:0] dut_mem [int];
    int wq[$];

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_o;

    twi_mem_target #(.ADDR_W(AW)) dut (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
        .sda_drive_o (sda_drive_o), .ce_i (ce), .wr_lock_i (lock),
        .mem_addr_o (mem_addr_o), .mem_we_o (mem_we_o), .mem_wdata_o (mem_wdata_o),
        .mem_re_o (mem_re_o), .mem_rdata_i (mem_rdata)
    );

    function automatic logic [7:0] get_ref(int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
    endfunction

    // behavioural memory behind the port
    always @(posedge clk) begin
        if (mem_re_o) mem_rdata <= dut_mem.exists(int'(mem_addr_o)) ? dut_mem[int'(mem_addr_o)] : 8'hFF;
        if (mem_we_o) dut_mem[int'(mem_addr_o)] = mem_wdata_o;
    end

    // per-clock comparison against the bench model
    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            vec++;
            if (sda_drive_o !== exp_drv) begin
                miss++;
                $display("FAIL %s: sda_drive_o actual %b expected %b at %0t", tag, sda_drive_o, exp_drv, $time);
            end
        end
        if (rst_n && mem_we_o) begin
            vec++;
            if (wq.size() == 0) begin
                miss++;
                $display("FAIL R8: store actual addr %h data %h expected none", mem_addr_o, mem_wdata_o);
            end else begin
                int e;
                e = wq.pop_front();
                if ({mem_addr_o, mem_wdata_o} !== 24'(e)) begin
                    miss++;
                    $display("FAIL R6: store actual %h%h expected %h", mem_addr_o, mem_wdata_o, 24'(e));
                end
            end
        end
    end

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic bit_cyc(input logic v, input logic e, input string t);
        sda_m = v;
        tick(LO);
        tag = t;
        exp_drv = e;
        scl_m = 1'b1;
        chk_en = 1'b1;
        tick(HI);
        chk_en = 1'b0;
        scl_m = 1'b0;
        tick(1);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input string t);
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], 1'b0, t);
        bit_cyc(1'b1, ack, t);
    endtask

    task automatic recv_byte(input logic [7:0] b, input logic mack, input string t);
        for (int i = 7; i >= 0; i--) bit_cyc(1'b1, ~b[i], t);
        bit_cyc(~mack, 1'b0, t);
    endtask

    task automatic do_start();
        if (!scl_m) begin
            sda_m = 1'b1; tick(LO);
            scl_m = 1'b1; tick(HI);
        end
        sda_m = 1'b0; tick(HI);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(LO);
        scl_m = 1'b1; tick(HI);
        sda_m = 1'b1; tick(HI);
    endtask

    task automatic wr_seq(input logic [7:0] sel, input int addr, input logic [7:0] d[$], input string t);
        do_start();
        send_byte(sel, 1'b1, "R3");
        send_byte(8'(addr >> 8), 1'b1, "R5");
        send_byte(8'(addr), 1'b1, "R5");
        ref_ptr = addr;
        foreach (d[i]) begin
            if (lock) begin
                send_byte(d[i], 1'b0, "R8");
                break;
            end
            wq.push_back((ref_ptr << 8) | int'(d[i]));
            ref_mem[ref_ptr] = d[i];
            send_byte(d[i], 1'b1, t);
            ref_ptr = (ref_ptr & 32'hFF00) | ((ref_ptr + 1) & 32'hFF);
        end
        do_stop();
    endtask

    task automatic rd_seq(input bit rnd, input int addr, input int cnt, input string t);
        do_start();
        if (rnd) begin
            send_byte(SEL_W, 1'b1, "R3");
            send_byte(8'(addr >> 8), 1'b1, "R5");
            send_byte(8'(addr), 1'b1, "R5");
            ref_ptr = addr;
            do_start();
        end
        send_byte(SEL_R, 1'b1, "R3");
        for (int i = 0; i < cnt; i++) begin
            recv_byte(get_ref(ref_ptr), i < cnt - 1, t);
            ref_ptr = (ref_ptr + 1) & 32'hFFFF;
        end
        send_byte(8'hFF, 1'b0, "R12");
        do_stop();
    endtask

    task automatic chk_idle(input string t);
        vec++;
        if (sda_drive_o !== 1'b0 || mem_we_o !== 1'b0 || mem_re_o !== 1'b0) begin
            miss++;
            $display("FAIL %s: drive/we/re actual %b%b%b expected 000", t, sda_drive_o, mem_we_o, mem_re_o);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL R12: watchdog actual cycles 200000 expected fewer");
        summary();
        $finish;
    end

    initial begin
        tick(3);
        chk_idle("R1");
        rst_n = 1'b1;
        tick(3);
        chk_idle("R1");

        wr_seq(SEL_W, 32'h1234, '{8'h5A}, "R6");
        rd_seq(1'b1, 32'h1234, 1, "R10");
        wr_seq(SEL_W, 32'h01FE, '{8'h11, 8'h22, 8'h33}, "R7");
        rd_seq(1'b1, 32'h01FE, 1, "R10");
        rd_seq(1'b0, 0, 1, "R9");
        rd_seq(1'b1, 32'h0100, 1, "R7");
        wr_seq(SEL_W, 32'h0000, '{8'h77}, "R6");
        rd_seq(1'b1, 32'hFFFF, 2, "R11");
        rd_seq(1'b1, 32'h01FE, 3, "R11");

        lock = 1'b1;
        wr_seq(SEL_W, 32'h1234, '{8'h99}, "R8");
        lock = 1'b0;
        rd_seq(1'b1, 32'h1234, 1, "R8");

        wr_seq(8'hAA, 32'h2000, '{8'h42}, "R3");
        rd_seq(1'b1, 32'h2000, 1, "R3");

        do_start();
        send_byte(8'hB8, 1'b0, "R3");
        send_byte(8'h00, 1'b0, "R4");
        do_stop();
        do_start();
        send_byte(8'hA4, 1'b0, "R3");
        send_byte(8'h55, 1'b0, "R4");
        do_stop();
        tick(2);
        chk_idle("R2");

        rd_seq(1'b1, 32'h0000, 1, "R10");

        vec++;
        if (wq.size() != 0) begin
            miss++;
            $display("FAIL R6: pending stores actual %0d expected 0", wq.size());
        end
        summary();
        $finish;
    end
endmodule